// File: doc/BRIEF.md
# DSP Float / IEEE Single Converter

This block translates numbers between a 32-bit signal-processor floating-point word and IEEE-754 single precision. It has two independent lanes that can run in the same cycle. The first lane turns a processor word into an IEEE single. The second lane turns an IEEE single into a processor word, and clamps results that fall outside the processor format.

The processor word has two fields. Bits 31:24 hold an 8-bit two's-complement exponent. Bits 23:0 hold a 24-bit two's-complement mantissa. Zero is not an all-zero word: it has its own code, exponent -128 with mantissa 0. Because the mantissa is two's-complement, a negative exact power of two takes an exponent one lower than the IEEE value would suggest.

Each lane is a purely combinational datapath followed by an output register with a valid flag. The register is chosen by a parameter and is present by default. The register loads only when its input valid is high, so a lane's result stays put between conversions.

Top module: `dspfp_ieee_conv`

## Requirements
- R1: While reset is asserted, and after its release until the first valid input, both valid outputs are 0 and both result buses are 0.
- R2: In the DSP-to-IEEE lane, input 0x80000000 (exponent field bits 31:24 = 0x80, mantissa bits 23:0 = 0) gives +0 (0x00000000). A word with exponent 0x80 and a nonzero mantissa is not treated as zero, and goes through the rules of R3 or R4.
- R3: In the DSP-to-IEEE lane, when mantissa bit 23 is 0, the result is ((exponent + 127) mod 512) shifted left by 23, plus the 24-bit mantissa, taken modulo 2^32.
- R4: In the DSP-to-IEEE lane, when mantissa bit 23 is 1, the mantissa is widened to M = mantissa shifted left by 8. The result is 0x80000000 plus ((exponent + 127) mod 512) shifted left by 23, plus bits 31:8 of -M, modulo 2^32.
- R5: In the IEEE-to-DSP lane, a positive input with a biased exponent E from 1 to 254 gives bits 31:24 = E - 127, bit 23 = 0, and the 23-bit fraction in bits 22:0.
- R6: In the IEEE-to-DSP lane, a negative input with E from 1 to 254 and a nonzero fraction F gives exponent E - 127. Its mantissa is bits 31:8 of (0x80000000 OR -(F shifted left by 8)).
- R7: In the IEEE-to-DSP lane, a negative input with E from 1 to 254 and a zero fraction gives exponent E - 128 and mantissa 0x800000.
- R8: In the IEEE-to-DSP lane, an input with E = 255 (infinity or NaN) saturates. A sign of 0 gives 0x7F7FFFFF and a sign of 1 gives 0x7F800000.
- R9: In the IEEE-to-DSP lane, an input with E = 0 (signed zero or denormal) gives the zero code 0x80000000.
- R10: Each lane's valid output equals its valid input from one clock earlier, and its result appears in that same cycle.
- R11: While a lane's valid input is low, that lane's result output keeps its last value. Activity on the other lane does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| d2i_vld_i | input | 1 | DSP-to-IEEE input valid |
| d2i_dsp_i | input | 32 | DSP word to convert |
| d2i_vld_o | output | 1 | DSP-to-IEEE result valid |
| d2i_ieee_o | output | 32 | IEEE single result |
| i2d_vld_i | input | 1 | IEEE-to-DSP input valid |
| i2d_ieee_i | input | 32 | IEEE single to convert |
| i2d_vld_o | output | 1 | IEEE-to-DSP result valid |
| i2d_dsp_o | output | 32 | DSP word result |

## Verification
With the default output stage, a conversion issued in one cycle shows its result and its raised valid flag after the next rising edge. The bench drives each input at a falling edge, waits one rising edge, and samples at the following falling edge. It never samples at the edge where the register loads. The hold checks drop the valid input, change the data input, and sample one full cycle later: that is the first moment a wrongly enabled register would show the new value. Internal reset release takes two more edges after `rst_n` rises, and the bench waits past those edges before it starts issuing conversions.

// File: rtl/dspfp_conv_pkg.sv
package dspfp_conv_pkg;

  localparam int WORD_W     = 32;
  localparam int EXP_W      = 8;
  localparam int MAN_W      = WORD_W - EXP_W;
  localparam int WIDE_PAD   = WORD_W - MAN_W;
  localparam int IEEE_EXP_W = 8;
  localparam int FRAC_W     = WORD_W - 1 - IEEE_EXP_W;
  localparam int IEEE_BIAS  = (1 << (IEEE_EXP_W - 1)) - 1;
  localparam int DSP_EXP_MIN = -(1 << (EXP_W - 1));
  localparam int DSP_EXP_MAX = (1 << (EXP_W - 1)) - 1;

  localparam logic [EXP_W-1:0]  EXP_ZERO_CODE = {1'b1, {(EXP_W-1){1'b0}}};
  localparam logic [EXP_W-1:0]  EXP_SAT_CODE  = {1'b0, {(EXP_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] SIGN_BIT      = {1'b1, {(WORD_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] ZERO_WORD     = {EXP_ZERO_CODE, {MAN_W{1'b0}}};

  typedef struct packed {
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } dsp_word_t;

  typedef struct packed {
    logic                  sign;
    logic [IEEE_EXP_W-1:0] exp;
    logic [FRAC_W-1:0]     frac;
  } ieee_word_t;

  typedef enum logic [1:0] {
    D2I_ZERO,
    D2I_POS,
    D2I_NEG
  } d2i_kind_e;

  typedef enum logic [2:0] {
    I2D_ZERO,
    I2D_SAT_POS,
    I2D_SAT_NEG,
    I2D_POS,
    I2D_NEG_FRAC,
    I2D_NEG_POW2
  } i2d_kind_e;

endpackage

// File: rtl/dspfp_rst_sync.sv
module dspfp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/dspfp_to_ieee.sv
module dspfp_to_ieee
  import dspfp_conv_pkg::*;
(
  input  dsp_word_t          dsp_i,
  output logic [WORD_W-1:0]  ieee_o
);

  logic [WORD_W-1:0] wide_man;
  logic [WORD_W-1:0] neg_man;
  logic [MAN_W-1:0]  neg_frac;
  logic [WORD_W-1:0] exp_ext;
  logic [WORD_W-1:0] bias_sum;
  logic [WORD_W-1:0] exp_field;
  d2i_kind_e         kind;

  // Widened mantissa, its negation and the rebiased exponent field.
  always_comb begin
    wide_man  = {dsp_i.man, {WIDE_PAD{1'b0}}};
    neg_man   = (~wide_man) + WORD_W'(1);
    neg_frac  = neg_man[WORD_W-1:WIDE_PAD];
    exp_ext   = {{(WORD_W-EXP_W){dsp_i.exp[EXP_W-1]}}, dsp_i.exp};
    bias_sum  = exp_ext + WORD_W'(IEEE_BIAS);
    exp_field = bias_sum << FRAC_W;
  end

  // Classify the input word.
  always_comb begin
    if ((dsp_i.exp == EXP_ZERO_CODE) && (wide_man == '0)) begin
      kind = D2I_ZERO;
    end else if (dsp_i.man[MAN_W-1]) begin
      kind = D2I_NEG;
    end else begin
      kind = D2I_POS;
    end
  end

  // Assemble the IEEE single.
  always_comb begin
    unique case (kind)
      D2I_ZERO: ieee_o = '0;
      D2I_POS:  ieee_o = exp_field + {{(WORD_W-MAN_W){1'b0}}, dsp_i.man};
      D2I_NEG:  ieee_o = SIGN_BIT + exp_field + {{(WORD_W-MAN_W){1'b0}}, neg_frac};
      default:  ieee_o = '0;
    endcase
  end

endmodule

// File: rtl/ieee_to_dspfp.sv
module ieee_to_dspfp
  import dspfp_conv_pkg::*;
(
  input  ieee_word_t         ieee_i,
  output logic [WORD_W-1:0]  dsp_o
);

  localparam int UNB_W = IEEE_EXP_W + 2;
  localparam logic signed [UNB_W-1:0] UNB_MIN  = UNB_W'(DSP_EXP_MIN);
  localparam logic signed [UNB_W-1:0] UNB_MAX  = UNB_W'(DSP_EXP_MAX);
  localparam logic signed [UNB_W-1:0] UNB_BIAS = UNB_W'(IEEE_BIAS);
  localparam logic [IEEE_EXP_W-1:0]   E_SPECIAL = {IEEE_EXP_W{1'b1}};
  localparam logic [WORD_W-1:0] SAT_POS_MAN = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] SAT_NEG_MAN = {1'b1, {(WORD_W-2){1'b0}}, 1'b1};

  logic signed [UNB_W-1:0] unb;
  logic [WORD_W-1:0]       wide_man;
  logic [WORD_W-1:0]       neg_man;
  logic [EXP_W-1:0]        exp_plain;
  logic [EXP_W-1:0]        exp_dec;
  i2d_kind_e               kind;
  logic [EXP_W-1:0]        exp_out;
  logic [WORD_W-1:0]       man_out;

  // Unbiased exponent and widened fraction.
  always_comb begin
    unb       = signed'({2'b00, ieee_i.exp}) - UNB_BIAS;
    wide_man  = {1'b0, ieee_i.frac, {WIDE_PAD{1'b0}}};
    neg_man   = (~wide_man) + WORD_W'(1);
    exp_plain = unb[EXP_W-1:0];
    exp_dec   = exp_plain - EXP_W'(1);
  end

  // Classify the input value.
  always_comb begin
    if ((ieee_i.exp == '0) || (unb < UNB_MIN)) begin
      kind = I2D_ZERO;
    end else if ((ieee_i.exp == E_SPECIAL) || (unb > UNB_MAX)) begin
      kind = ieee_i.sign ? I2D_SAT_NEG : I2D_SAT_POS;
    end else if (!ieee_i.sign) begin
      kind = I2D_POS;
    end else if (ieee_i.frac != '0) begin
      kind = I2D_NEG_FRAC;
    end else begin
      kind = I2D_NEG_POW2;
    end
  end

  // Select exponent and widened mantissa per class.
  always_comb begin
    unique case (kind)
      I2D_ZERO: begin
        exp_out = EXP_ZERO_CODE;
        man_out = '0;
      end
      I2D_SAT_POS: begin
        exp_out = EXP_SAT_CODE;
        man_out = SAT_POS_MAN;
      end
      I2D_SAT_NEG: begin
        exp_out = EXP_SAT_CODE;
        man_out = SAT_NEG_MAN;
      end
      I2D_POS: begin
        exp_out = exp_plain;
        man_out = wide_man;
      end
      I2D_NEG_FRAC: begin
        exp_out = exp_plain;
        man_out = SIGN_BIT | neg_man;
      end
      I2D_NEG_POW2: begin
        exp_out = exp_dec;
        man_out = SIGN_BIT;
      end
      default: begin
        exp_out = EXP_ZERO_CODE;
        man_out = '0;
      end
    endcase
  end

  assign dsp_o = {exp_out, man_out[WORD_W-1:WIDE_PAD]};

endmodule

// File: rtl/dspfp_out_stage.sv
module dspfp_out_stage #(
  parameter int W       = 32,
  parameter int REG_OUT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] data_i,
  output logic         vld_o,
  output logic [W-1:0] data_o
);

  generate
    if (REG_OUT != 0) begin : g_reg
      logic         vld_q;
      logic         vld_d;
      logic [W-1:0] data_q;
      logic [W-1:0] data_d;

      always_comb begin
        vld_d  = vld_i;
        data_d = data_q;
        if (vld_i) begin
          data_d = data_i;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          data_q <= '0;
        end else begin
          vld_q  <= vld_d;
          data_q <= data_d;
        end
      end

      assign vld_o  = vld_q;
      assign data_o = data_q;
    end else begin : g_pass
      assign vld_o  = vld_i;
      assign data_o = data_i;
    end
  endgenerate

endmodule

// File: rtl/dspfp_ieee_conv.sv
module dspfp_ieee_conv
  import dspfp_conv_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d2i_vld_i,
  input  logic [WORD_W-1:0] d2i_dsp_i,
  output logic              d2i_vld_o,
  output logic [WORD_W-1:0] d2i_ieee_o,
  input  logic              i2d_vld_i,
  input  logic [WORD_W-1:0] i2d_ieee_i,
  output logic              i2d_vld_o,
  output logic [WORD_W-1:0] i2d_dsp_o
);

  logic              rst_sync_n;
  dsp_word_t         d2i_word;
  ieee_word_t        i2d_word;
  logic [WORD_W-1:0] d2i_comb;
  logic [WORD_W-1:0] i2d_comb;

  assign d2i_word = dsp_word_t'(d2i_dsp_i);
  assign i2d_word = ieee_word_t'(i2d_ieee_i);

  dspfp_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dspfp_to_ieee u_d2i (
    .dsp_i  (d2i_word),
    .ieee_o (d2i_comb)
  );

  ieee_to_dspfp u_i2d (
    .ieee_i (i2d_word),
    .dsp_o  (i2d_comb)
  );

  dspfp_out_stage #(.W(WORD_W), .REG_OUT(REG_OUT)) u_d2i_out (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .vld_i  (d2i_vld_i),
    .data_i (d2i_comb),
    .vld_o  (d2i_vld_o),
    .data_o (d2i_ieee_o)
  );

  dspfp_out_stage #(.W(WORD_W), .REG_OUT(REG_OUT)) u_i2d_out (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .vld_i  (i2d_vld_i),
    .data_i (i2d_comb),
    .vld_o  (i2d_vld_o),
    .data_o (i2d_dsp_o)
  );

endmodule

// File: rtl/dspfp_ieee_conv_chk.sv
module dspfp_ieee_conv_chk
  import dspfp_conv_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              d2i_vld_i,
  input logic [WORD_W-1:0] d2i_dsp_i,
  input logic              d2i_vld_o,
  input logic [WORD_W-1:0] d2i_ieee_o,
  input logic              i2d_vld_i,
  input logic [WORD_W-1:0] i2d_ieee_i,
  input logic              i2d_vld_o,
  input logic [WORD_W-1:0] i2d_dsp_o
);

  localparam int EXP_LSB  = WORD_W - EXP_W;
  localparam int IEXP_LSB = FRAC_W;
  localparam logic [IEEE_EXP_W-1:0] E_SPECIAL = {IEEE_EXP_W{1'b1}};

  generate
    if (REG_OUT != 0) begin : g_chk
      // R10
      d2i_vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        d2i_vld_i |=> d2i_vld_o);
      // R10
      d2i_vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !d2i_vld_i |=> !d2i_vld_o);
      // R10
      i2d_vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        i2d_vld_i |=> i2d_vld_o);
      // R10
      i2d_vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !i2d_vld_i |=> !i2d_vld_o);
      // R11
      d2i_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !d2i_vld_i |=> $stable(d2i_ieee_o));
      // R11
      i2d_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !i2d_vld_i |=> $stable(i2d_dsp_o));
      // R2
      d2i_zero_code_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (d2i_vld_i && (d2i_dsp_i == ZERO_WORD)) |=> (d2i_ieee_o == '0));
      // R4
      d2i_neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (d2i_vld_i && d2i_dsp_i[MAN_W-1] && (d2i_dsp_i[WORD_W-1:EXP_LSB] != EXP_ZERO_CODE))
        |=> d2i_ieee_o[WORD_W-1]);
      // R8
      i2d_sat_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (i2d_vld_i && (i2d_ieee_i[WORD_W-2:IEXP_LSB] == E_SPECIAL))
        |=> (i2d_dsp_o[WORD_W-1:EXP_LSB] == EXP_SAT_CODE));
      // R9
      i2d_zero_code_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (i2d_vld_i && (i2d_ieee_i[WORD_W-2:IEXP_LSB] == '0)) |=> (i2d_dsp_o == ZERO_WORD));
      // R6 and R7: normal negative inputs keep a set mantissa sign bit
      i2d_neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (i2d_vld_i && i2d_ieee_i[WORD_W-1] && (i2d_ieee_i[WORD_W-2:IEXP_LSB] != '0)
         && (i2d_ieee_i[WORD_W-2:IEXP_LSB] != E_SPECIAL)) |=> i2d_dsp_o[MAN_W-1]);
    end
  endgenerate

endmodule

bind dspfp_ieee_conv dspfp_ieee_conv_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .d2i_vld_i  (d2i_vld_i),
  .d2i_dsp_i  (d2i_dsp_i),
  .d2i_vld_o  (d2i_vld_o),
  .d2i_ieee_o (d2i_ieee_o),
  .i2d_vld_i  (i2d_vld_i),
  .i2d_ieee_i (i2d_ieee_i),
  .i2d_vld_o  (i2d_vld_o),
  .i2d_dsp_o  (i2d_dsp_o)
);

// File: tb/test_dspfp_ieee_conv.sv
module test_dspfp_ieee_conv;

  localparam int CLK_PERIOD = 10;
  localparam int N = 15;

  // Columns: DSP in, IEEE expected (requirement) | IEEE in, DSP expected (requirement)
  localparam logic [31:0] D2I_IN [0:N-1] = '{
    32'h80000000, 32'h00000000, 32'h01000000, 32'hFF000000, 32'h7F7FFFFF,
    32'h00400000, 32'h02200000, 32'h81000000, 32'hFF800000, 32'h00C00000,
    32'h01C00000, 32'hFFE00000, 32'h7F800000, 32'h80400000, 32'h81800000};
  localparam logic [31:0] D2I_EXP [0:N-1] = '{
    32'h00000000, 32'h3F800000, 32'h40000000, 32'h3F000000, 32'h7F7FFFFF,
    32'h3FC00000, 32'h40A00000, 32'h00000000, 32'hBF800000, 32'hBFC00000,
    32'hC0400000, 32'hBF200000, 32'hFF800000, 32'hFFC00000, 32'h80800000};
  // R2 zero code and exp -128 non-zero, R3 positive mantissa, R4 negative mantissa
  localparam int D2I_REQ [0:N-1] = '{2, 3, 3, 3, 3, 3, 3, 3, 4, 4, 4, 4, 4, 2, 4};

  localparam logic [31:0] I2D_IN [0:N-1] = '{
    32'h3F800000, 32'h40000000, 32'h3F000000, 32'h7F7FFFFF, 32'h00800000,
    32'hBFC00000, 32'hC0400000, 32'hBF800000, 32'h7F800000, 32'hFF800000,
    32'h7FC00000, 32'h00000000, 32'h80000000, 32'h00000001, 32'h80800000};
  localparam logic [31:0] I2D_EXP [0:N-1] = '{
    32'h00000000, 32'h01000000, 32'hFF000000, 32'h7F7FFFFF, 32'h82000000,
    32'h00C00000, 32'h01C00000, 32'hFF800000, 32'h7F7FFFFF, 32'h7F800000,
    32'h7F7FFFFF, 32'h80000000, 32'h80000000, 32'h80000000, 32'h81800000};
  // R5 positive normal, R6 negative fraction, R7 negative power of two, R8 saturation, R9 zero code
  localparam int I2D_REQ [0:N-1] = '{5, 5, 5, 5, 5, 6, 6, 7, 8, 8, 8, 9, 9, 9, 7};

  logic        clk;
  logic        rst_n;
  logic        d2i_vld_i;
  logic [31:0] d2i_dsp_i;
  logic        d2i_vld_o;
  logic [31:0] d2i_ieee_o;
  logic        i2d_vld_i;
  logic [31:0] i2d_ieee_i;
  logic        i2d_vld_o;
  logic [31:0] i2d_dsp_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  dspfp_ieee_conv i_dspfp_ieee_conv (
    .clk        (clk),
    .rst_n      (rst_n),
    .d2i_vld_i  (d2i_vld_i),
    .d2i_dsp_i  (d2i_dsp_i),
    .d2i_vld_o  (d2i_vld_o),
    .d2i_ieee_o (d2i_ieee_o),
    .i2d_vld_i  (i2d_vld_i),
    .i2d_ieee_i (i2d_ieee_i),
    .i2d_vld_o  (i2d_vld_o),
    .i2d_dsp_o  (i2d_dsp_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    d2i_vld_i  = 1'b0;
    d2i_dsp_i  = '0;
    i2d_vld_i  = 1'b0;
    i2d_ieee_i = '0;
    repeat (3) @(negedge clk);
    // R1: during reset
    chk("R1", "d2i valid in reset", {31'b0, d2i_vld_o}, 32'd0);
    chk("R1", "i2d valid in reset", {31'b0, i2d_vld_o}, 32'd0);
    chk("R1", "d2i data in reset", d2i_ieee_o, 32'd0);
    chk("R1", "i2d data in reset", i2d_dsp_o, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: after release, before any valid input
    chk("R1", "d2i valid after release", {31'b0, d2i_vld_o}, 32'd0);
    chk("R1", "i2d data after release", i2d_dsp_o, 32'd0);

    // Both lanes at once, one vector per cycle
    for (int i = 0; i < N; i++) begin
      d2i_dsp_i  = D2I_IN[i];
      i2d_ieee_i = I2D_IN[i];
      d2i_vld_i  = 1'b1;
      i2d_vld_i  = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R10", "d2i valid one cycle later", {31'b0, d2i_vld_o}, 32'd1);
      chk("R10", "i2d valid one cycle later", {31'b0, i2d_vld_o}, 32'd1);
      chk($sformatf("R%0d", D2I_REQ[i]), $sformatf("d2i vec %0d", i), d2i_ieee_o, D2I_EXP[i]);
      chk($sformatf("R%0d", I2D_REQ[i]), $sformatf("i2d vec %0d", i), i2d_dsp_o, I2D_EXP[i]);
    end

    // R11: valid low, inputs change, outputs hold; R10 valid drops
    d2i_vld_i  = 1'b0;
    i2d_vld_i  = 1'b0;
    d2i_dsp_i  = 32'h12345678;
    i2d_ieee_i = 32'h3F800000;
    @(posedge clk);
    @(negedge clk);
    chk("R10", "d2i valid drops", {31'b0, d2i_vld_o}, 32'd0);
    chk("R10", "i2d valid drops", {31'b0, i2d_vld_o}, 32'd0);
    chk("R11", "d2i holds when idle", d2i_ieee_o, D2I_EXP[N-1]);
    chk("R11", "i2d holds when idle", i2d_dsp_o, I2D_EXP[N-1]);

    // R11: only the DSP-to-IEEE lane fires
    d2i_dsp_i = 32'h00000000;
    d2i_vld_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    d2i_vld_i = 1'b0;
    chk("R3", "d2i lone conversion", d2i_ieee_o, 32'h3F800000);
    chk("R11", "i2d untouched by other lane", i2d_dsp_o, I2D_EXP[N-1]);
    chk("R11", "i2d valid stays low", {31'b0, i2d_vld_o}, 32'd0);

    // R11: only the IEEE-to-DSP lane fires (-2.5, R6)
    i2d_ieee_i = 32'hC0200000;
    i2d_vld_i  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    i2d_vld_i = 1'b0;
    chk("R6", "i2d lone conversion", i2d_dsp_o, 32'h01E00000);
    chk("R11", "d2i untouched by other lane", d2i_ieee_o, 32'h3F800000);
    chk("R10", "d2i valid low after one shot", {31'b0, d2i_vld_o}, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule